// File: doc/BRIEF.md
# Coin-Operated Drink Vending Controller

This block is the sequencing core of a drink dispenser with ten selections. It counts quarters as they arrive on a coin-trigger pulse input. Once the fixed price of three quarters is held, it accepts a drink selection. It refuses any selection whose stock sensor reports empty. A refund button returns everything held. Each event gives a one-clock strobe on a drink-release line or on the coin-return line.

The decision logic is a constant lookup table. Its address is the coin count held, concatenated with a compressed view of the inputs: the refund button, the coin trigger, and a flag saying "an in-stock selection is requested". Each table word is the next coin count concatenated with the two output enables. A priority picker sits in front of the table. It reduces the ten select lines and ten sold-out lines to that flag and to a one-hot grant. The grant steers the release strobe to the chosen line.

The selection count and the price in coins are parameters. The defaults give ten lines and a three-coin price with a 2-bit coin register.

Top module: `drink_vend_ctrl`

## Requirements
- R1: While reset is active and on the first cycle after it, no release or refund strobe is driven, and the coin count held is zero.
- R2: A coin pulse received with fewer than three coins held (refund not pressed) adds one coin. Up to the third coin, no strobe is produced.
- R3: A selection made with fewer than three coins held releases nothing and leaves the coins held unchanged.
- R4: A selection on line k (bit k of the select bus) made with three coins held and line k in stock strobes release bit k for one clock. The count then returns to zero.
- R5: A selection whose sold-out bit is 1 (empty) releases nothing and keeps all three coins.
- R6: When several select bits are high, only the lowest-numbered line whose sold-out bit is 0 is served.
- R7: Refund pressed while coins are held, or together with a coin pulse, gives one refund strobe and clears the count. Refund pressed with nothing held and no coin gives no strobe.
- R8: A coin pulse received with three coins held is returned at once with a refund strobe, and the three coins stay held.
- R9: Refund has priority over a simultaneous selection and coin: no release, one refund strobe, count cleared.
- R10: Strobes are registered. They appear on the clock edge that samples the causing inputs and last exactly one clock. At most one release bit is high at a time.
- R11: A coin pulse and a valid selection in the same cycle with three coins held give both the release strobe and a refund strobe, and the count returns to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| coin_i | input | 1 | One-cycle pulse per quarter inserted |
| refund_i | input | 1 | One-cycle refund button pulse |
| sel_i | input | NUM_SEL | Drink-select lines, bit k = selection k |
| soldout_i | input | NUM_SEL | Stock sensors, 1 = selection empty |
| release_o | output | NUM_SEL | One-clock drink-release strobes |
| refund_o | output | 1 | One-clock coin-return strobe |

## Verification
The coin count is not visible at the ports. It can only be inferred from what a later selection or refund does. The hardest cases are the collisions in the full state: a coin arriving together with a selection, and a refund colliding with both. The bench first reaches three coins with separate pulses. It then applies the collision in one cycle, and follows it with a probing selection. That probe shows whether the coins were kept or cleared. Sold-out lockout is probed the same way, by freeing the line afterwards and showing that the same coins still buy it.

// File: rtl/vend_pkg.sv
package vend_pkg;

   // address field positions below the coin-count field
   localparam int ADR_VLD = 0;
   localparam int ADR_COIN = 1;
   localparam int ADR_REFUND = 2;
   localparam int ADR_LOW_W = 3;

   typedef struct packed {
      logic [7:0] nxt;
      logic       ret;
      logic       rel;
   } vend_act_t;

   // rule for one table word; full is the price in coins
   function automatic vend_act_t vend_rule(input int held, input int refund,
                                           input int coin, input int vld,
                                           input int full);
      vend_act_t act;
      act.nxt = (held > full) ? 8'd0 : 8'(held);
      act.ret = 1'b0;
      act.rel = 1'b0;
      if (refund != 0) begin
         act.nxt = 8'd0;
         act.ret = (held != 0) || (coin != 0);
      end else if (held == full) begin
         if (vld != 0) begin
            act.rel = 1'b1;
            act.nxt = 8'd0;
         end
         if (coin != 0) act.ret = 1'b1;
      end else if (held < full && coin != 0) begin
         act.nxt = 8'(held + 1);
      end
      return act;
   endfunction

endpackage

// File: rtl/vend_pick.sv
module vend_pick #(
   parameter int N = 10,
   parameter int STYLE = 0   // 0: carry isolate, 1: ripple chain
) (
   input  logic [N-1:0] req_i,
   input  logic [N-1:0] empty_i,
   output logic [N-1:0] grant_o,
   output logic         vld_o
);
   logic [N-1:0] elig;
   assign elig = req_i & ~empty_i;
   assign vld_o = |elig;

   generate
      if (STYLE == 0) begin : g_isolate
         assign grant_o = elig & (~elig + N'(1));
      end else begin : g_chain
         logic [N:0] blocked;
         assign blocked[0] = 1'b0;
         for (genvar k = 0; k < N; k++) begin : g_bit
            assign grant_o[k] = elig[k] & ~blocked[k];
            assign blocked[k+1] = blocked[k] | elig[k];
         end
      end
   endgenerate

   always_comb begin
      AST_GRANT_ONEHOT: assert ($onehot0(grant_o)); // R6
      AST_GRANT_STOCKED: assert ((grant_o & empty_i) == '0); // R5
   end

   if (STYLE != 0 && STYLE != 1) begin : g_bad_style
      $error("vend_pick: STYLE must be 0 or 1");
   end
endmodule

// File: rtl/vend_rule_rom.sv
module vend_rule_rom #(
   parameter int STATE_W = 2,
   parameter int FULL = 3
) (
   input  logic [STATE_W+vend_pkg::ADR_LOW_W-1:0] addr_i,
   output logic [STATE_W-1:0]                     nxt_o,
   output logic                                   ret_o,
   output logic                                   rel_o
);
   import vend_pkg::*;

   localparam int ADDR_W = STATE_W + ADR_LOW_W;
   localparam int DEPTH = 1 << ADDR_W;
   localparam int WORD_W = STATE_W + 2;

   logic [WORD_W-1:0] tbl [DEPTH];

   generate
      for (genvar a = 0; a < DEPTH; a++) begin : g_word
         localparam vend_act_t ACT = vend_rule(a >> ADR_LOW_W,
                                               (a >> ADR_REFUND) & 1,
                                               (a >> ADR_COIN) & 1,
                                               (a >> ADR_VLD) & 1, FULL);
         assign tbl[a] = {ACT.nxt[STATE_W-1:0], ACT.ret, ACT.rel};
      end
   endgenerate

   logic [WORD_W-1:0] word;
   assign word = tbl[addr_i];
   assign {nxt_o, ret_o, rel_o} = word;

   if (FULL >= (1 << STATE_W)) begin : g_bad_w
      $error("vend_rule_rom: STATE_W too narrow for FULL");
   end
endmodule

// File: rtl/drink_vend_ctrl.sv
module drink_vend_ctrl #(
   parameter int NUM_SEL = 10,
   parameter int PRICE_COINS = 3,
   parameter int PICK_STYLE = 0
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic               coin_i,
   input  logic               refund_i,
   input  logic [NUM_SEL-1:0] sel_i,
   input  logic [NUM_SEL-1:0] soldout_i,
   output logic [NUM_SEL-1:0] release_o,
   output logic               refund_o
);
   import vend_pkg::*;

   localparam int STATE_W = (PRICE_COINS < 2) ? 1 : $clog2(PRICE_COINS + 1);
   localparam logic [STATE_W-1:0] FULL_ST = STATE_W'(PRICE_COINS);

   if (NUM_SEL < 1) begin : g_bad_sel
      $error("drink_vend_ctrl: NUM_SEL must be at least 1");
   end
   if (PRICE_COINS < 1 || PRICE_COINS > 255) begin : g_bad_price
      $error("drink_vend_ctrl: PRICE_COINS out of range");
   end

   logic [NUM_SEL-1:0] grant;
   logic               sel_vld;

   vend_pick #(.N(NUM_SEL), .STYLE(PICK_STYLE)) u_pick (
      .req_i  (sel_i),
      .empty_i(soldout_i),
      .grant_o(grant),
      .vld_o  (sel_vld)
   );

   logic [STATE_W-1:0] coins_q;
   logic [STATE_W-1:0] coins_d;
   logic               ret_en;
   logic               rel_en;

   vend_rule_rom #(.STATE_W(STATE_W), .FULL(PRICE_COINS)) u_rom (
      .addr_i({coins_q, refund_i, coin_i, sel_vld}),
      .nxt_o (coins_d),
      .ret_o (ret_en),
      .rel_o (rel_en)
   );

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         coins_q   <= '0;
         release_o <= '0;
         refund_o  <= 1'b0;
      end else begin
         coins_q   <= coins_d;
         release_o <= rel_en ? grant : '0;
         refund_o  <= ret_en;
      end
   end

   AST_REL_ONEHOT: assert property (@(posedge clk_i) disable iff (rst_i)
      $onehot0(release_o)); // R10
   AST_NO_REL_UNPAID: assert property (@(posedge clk_i) disable iff (rst_i)
      (coins_q != FULL_ST) |=> (release_o == '0)); // R3
   AST_REFUND_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
      refund_i |=> (coins_q == '0 && release_o == '0)); // R9
   AST_COIN_COUNT: assert property (@(posedge clk_i) disable iff (rst_i)
      (coin_i && !refund_i && coins_q < FULL_ST) |=>
         (coins_q == $past(coins_q) + STATE_W'(1))); // R2
   AST_OVERPAY_RET: assert property (@(posedge clk_i) disable iff (rst_i)
      (coin_i && !refund_i && coins_q == FULL_ST) |=> refund_o); // R8
   AST_REFUND_ONE_CLK: assert property (@(posedge clk_i) disable iff (rst_i)
      (refund_o && !$past(refund_i) && !$past(coin_i)) |-> 1'b0); // R10

   for (genvar k = 0; k < NUM_SEL; k++) begin : g_line_chk
      AST_SOLDOUT_LOCK: assert property (@(posedge clk_i) disable iff (rst_i)
         (soldout_i[k] || !sel_i[k]) |=> !release_o[k]); // R5
   end
endmodule

// File: tb/drink_vend_ctrl_bench.sv
module drink_vend_ctrl_bench;
   localparam int N = 10;

   logic         clk = 1'b0;
   logic         rst;
   logic         coin, refund;
   logic [N-1:0] sel, soldout;
   logic [N-1:0] rel;
   logic         ret;

   int nchk = 0;
   int nbad = 0;
   logic [N-1:0] got_rel;
   logic         got_ret;

   always #2 clk = ~clk;

   drink_vend_ctrl #(.NUM_SEL(N), .PRICE_COINS(3)) u_drink_vend_ctrl (
      .clk_i(clk), .rst_i(rst), .coin_i(coin), .refund_i(refund),
      .sel_i(sel), .soldout_i(soldout), .release_o(rel), .refund_o(ret)
   );

   task automatic check(input string tag, input logic [N-1:0] g_rel,
                        input logic g_ret, input logic [N-1:0] e_rel,
                        input logic e_ret);
      nchk++;
      if (g_rel !== e_rel || g_ret !== e_ret) begin
         nbad++;
         $display("FAIL %s: release=%b refund=%b expected release=%b refund=%b",
                  tag, g_rel, g_ret, e_rel, e_ret);
      end
   endtask

   // one input cycle; captures outputs registered at the sampling edge
   task automatic step(input logic c, input logic r, input logic [N-1:0] s);
      @(negedge clk);
      coin = c; refund = r; sel = s;
      @(posedge clk);
      #1;
      got_rel = rel; got_ret = ret;
      coin = 1'b0; refund = 1'b0; sel = '0;
   endtask

   task automatic pay(input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         step(1'b1, 1'b0, '0);
         check(tag, got_rel, got_ret, '0, 1'b0);
      end
   endtask

   task automatic t_reset;
      rst = 1'b1; coin = 0; refund = 0; sel = '0; soldout = '0;
      repeat (3) @(posedge clk);
      #1;
      check("R1 during reset", rel, ret, '0, 1'b0);
      @(negedge clk); rst = 1'b0;
      step(1'b0, 1'b0, '0);
      check("R1 first cycle", got_rel, got_ret, '0, 1'b0);
      step(1'b0, 1'b0, N'(1) << 2);
      check("R1 zero coins held", got_rel, got_ret, '0, 1'b0);
   endtask

   task automatic t_buy(input int k);
      pay(3, "R2 coin no strobe");
      step(1'b0, 1'b0, N'(1) << k);
      check("R4 release line", got_rel, got_ret, N'(1) << k, 1'b0);
      step(1'b0, 1'b0, '0);
      check("R10 one clock", got_rel, got_ret, '0, 1'b0);
      step(1'b0, 1'b0, N'(1) << k);
      check("R4 count back to zero", got_rel, got_ret, '0, 1'b0);
   endtask

   task automatic t_underpaid;
      pay(2, "R2 two coins");
      step(1'b0, 1'b0, N'(1) << 3);
      check("R3 underpaid select", got_rel, got_ret, '0, 1'b0);
      pay(1, "R2 third coin");
      step(1'b0, 1'b0, N'(1) << 3);
      check("R3 coins kept", got_rel, got_ret, N'(1) << 3, 1'b0);
   endtask

   task automatic t_soldout;
      pay(3, "R2 pay");
      soldout = N'(1) << 4;
      step(1'b0, 1'b0, N'(1) << 4);
      check("R5 empty refused", got_rel, got_ret, '0, 1'b0);
      soldout = '0;
      step(1'b0, 1'b0, N'(1) << 4);
      check("R5 coins kept", got_rel, got_ret, N'(1) << 4, 1'b0);
   endtask

   task automatic t_multi;
      pay(3, "R2 pay");
      soldout = N'(1) << 2;
      step(1'b0, 1'b0, (N'(1) << 2) | (N'(1) << 5) | (N'(1) << 7));
      check("R6 lowest in stock", got_rel, got_ret, N'(1) << 5, 1'b0);
      soldout = '0;
      pay(3, "R2 pay");
      step(1'b0, 1'b0, '1);
      check("R6 all pressed", got_rel, got_ret, N'(1), 1'b0);
   endtask

   task automatic t_refund;
      pay(2, "R2 pay");
      step(1'b0, 1'b1, '0);
      check("R7 refund pulse", got_rel, got_ret, '0, 1'b1);
      step(1'b0, 1'b0, '0);
      check("R10 refund one clock", got_rel, got_ret, '0, 1'b0);
      pay(2, "R2 pay");
      step(1'b0, 1'b0, N'(1) << 1);
      check("R7 count cleared", got_rel, got_ret, '0, 1'b0);
      step(1'b0, 1'b1, '0);
      step(1'b0, 1'b1, '0);
      check("R7 empty refund silent", got_rel, got_ret, '0, 1'b0);
      step(1'b1, 1'b1, '0);
      check("R7 refund with coin", got_rel, got_ret, '0, 1'b1);
   endtask

   task automatic t_overpay;
      pay(3, "R2 pay");
      step(1'b1, 1'b0, '0);
      check("R8 extra coin returned", got_rel, got_ret, '0, 1'b1);
      step(1'b0, 1'b0, N'(1) << 0);
      check("R8 still full", got_rel, got_ret, N'(1), 1'b0);
   endtask

   task automatic t_refund_prio;
      pay(3, "R2 pay");
      step(1'b1, 1'b1, N'(1) << 6);
      check("R9 refund wins", got_rel, got_ret, '0, 1'b1);
      step(1'b0, 1'b0, N'(1) << 6);
      check("R9 cleared", got_rel, got_ret, '0, 1'b0);
   endtask

   task automatic t_coin_sel;
      pay(3, "R2 pay");
      step(1'b1, 1'b0, N'(1) << 9);
      check("R11 release and return", got_rel, got_ret, N'(1) << 9, 1'b1);
      step(1'b0, 1'b0, N'(1) << 9);
      check("R11 count zero", got_rel, got_ret, '0, 1'b0);
   endtask

   initial begin
      t_reset;
      t_buy(0);
      t_buy(9);
      t_underpaid;
      t_soldout;
      t_multi;
      t_refund;
      t_overpay;
      t_refund_prio;
      t_coin_sel;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
   end

   initial begin
      #200000;
      nchk++;
      nbad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
   end
endmodule